// File: doc/BRIEF.md
# Receive Frame Discard Filter

This block sits between a receive MAC byte stream and the receive FIFO. Every byte that arrives is passed on as a FIFO write unless the frame it belongs to has been condemned. Five error causes are checked: FIFO overflow, a bad CRC reported on the last byte, a frame longer than a programmable limit, a frame shorter than the minimum, and an abort raised by the system side while it is reading a frame out. Any cause whose keep bit is clear condemns the frame.

When a frame is condemned, the block pulses a flush to the FIFO, sets a sticky discard flag and stops passing bytes. The flag stays set until the clear input is raised, and it also blocks writes while it is set. Once the flag is clear, passing resumes at the first byte of the next frame, never in the middle of a frame. The length limit is 1518 plus a 4-bit select value, so it runs from 1518 to 1533 bytes. Frame lengths count every byte that is delivered, with preamble and SFD excluded.

Top module: `rx_discard_filter`

## Requirements
- R1: After reset, `discard_flag`, `in_block` and `fifo_flush` are low.
- R2: A frame of 64 to max bytes with no error has every byte written unchanged, and no flush occurs. A byte is written when `fifo_wr_en` is high in the same cycle as `in_valid`.
- R3: A frame whose last byte comes with `crc_err` high is discarded when `keep_mask[1]` is 0.
- R4: A frame shorter than 64 bytes is discarded at its last byte when `keep_mask[3]` is 0. A frame of exactly 64 bytes is kept.
- R5: The size limit is 1518 + `max_sel`. When the byte count passes the limit, the discard fires on that byte without waiting for the end of the frame, provided `keep_mask[2]` is 0. A frame of exactly the limit is kept.
- R6: A frame byte that arrives while `fifo_full` is high causes a discard when `keep_mask[0]` is 0.
- R7: `sys_abort` together with `rd_active` causes a discard when `keep_mask[4]` is 0. `sys_abort` while `rd_active` is low has no effect.
- R8: When a cause's keep bit is 1, that cause alone discards nothing and every byte of the frame is written.
- R9: A discard pulses `fifo_flush` in the cycle after the byte or event that triggered it. The byte that triggered it is not written.
- R10: After a discard, no byte is written until a frame starts while `discard_flag` is low. `discard_flag` stays high until `clr_discard` is raised, and no write occurs while it is high.
- R11: If `clr_discard` and a new discard fall in the same cycle, `discard_flag` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A receive byte is present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Receive byte |
| crc_err | input | 1 | CRC error, valid on the last byte |
| fifo_full | input | 1 | Receive FIFO is full |
| rd_active | input | 1 | System side is reading a frame out |
| sys_abort | input | 1 | System-side abort request |
| keep_mask | input | 5 | Per-cause keep bits: 0 overflow, 1 CRC, 2 oversize, 3 undersize, 4 abort |
| max_sel | input | 4 | Size limit offset above 1518 |
| clr_discard | input | 1 | Clears the sticky discard flag |
| fifo_wr_en | output | 1 | Write the byte into the FIFO |
| fifo_wr_data | output | 8 | Byte written to the FIFO |
| fifo_flush | output | 1 | One-cycle FIFO flush |
| in_block | output | 1 | FIFO input is blocked |
| discard_flag | output | 1 | Sticky discard indication |

## Verification
The assertions assume that `in_sof` and `in_eof` are only seen together with `in_valid`, and that frames do not overlap. They also assume that `max_sel` and `keep_mask` stay steady while a frame is in flight, and that `crc_err` matters only on a last byte. The bench keeps to these rules. It drives whole frames through one task with markers on the first and last bytes, raises `crc_err` only on the last byte, and changes the mask and the limit only between frames.

// File: rtl/rx_discard_filter.sv
module rx_discard_filter #(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 11,
  parameter int SEL_W    = 4,
  parameter int MIN_LEN  = 64,
  parameter int BASE_MAX = 1518,
  parameter int NCAUSE   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  input  logic              crc_err,
  input  logic              fifo_full,
  input  logic              rd_active,
  input  logic              sys_abort,
  input  logic [NCAUSE-1:0] keep_mask,
  input  logic [SEL_W-1:0]  max_sel,
  input  logic              clr_discard,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              fifo_flush,
  output logic              in_block,
  output logic              discard_flag
);
  localparam logic [LEN_W-1:0] CNT_SAT = '1;
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);

  logic             in_frame, drop, flag_q, flush_q;
  logic [LEN_W-1:0] cnt_q;

  wire [LEN_W-1:0] max_len = LEN_W'(BASE_MAX) + LEN_W'(max_sel);
  wire             accept  = in_valid & (in_sof | in_frame);
  wire             live    = accept & ~flag_q & ~(drop & ~in_sof);
  wire [LEN_W-1:0] cnt_nx  = in_sof ? LEN_W'(1) :
                             (cnt_q == CNT_SAT) ? cnt_q : cnt_q + LEN_W'(1);

  logic [NCAUSE-1:0] cause;
  always_comb begin
    cause    = '0;
    cause[0] = live & fifo_full;
    cause[1] = live & in_eof & crc_err;
    cause[2] = live & (cnt_nx > max_len);
    cause[3] = live & in_eof & (cnt_nx < MIN_L);
    cause[4] = rd_active & sys_abort;
  end

  wire trig = |(cause & ~keep_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt_q    <= '0;
      drop     <= 1'b0;
      flag_q   <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      if (accept) begin
        in_frame <= ~in_eof;
        cnt_q    <= cnt_nx;
      end
      if (trig)
        drop <= 1'b1;
      else if (accept & in_sof)
        drop <= flag_q;
      flag_q  <= trig | (flag_q & ~clr_discard);
      flush_q <= trig;
    end
  end

  assign fifo_wr_en   = live & ~trig;
  assign fifo_wr_data = in_data;
  assign fifo_flush   = flush_q;
  assign in_block     = drop | flag_q;
  assign discard_flag = flag_q;
endmodule

module rx_discard_filter_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  parameter int NCAUSE = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [DATA_W-1:0] in_data,
  input logic              crc_err,
  input logic              fifo_full,
  input logic              rd_active,
  input logic              sys_abort,
  input logic [NCAUSE-1:0] keep_mask,
  input logic [SEL_W-1:0]  max_sel,
  input logic              clr_discard,
  input logic              fifo_wr_en,
  input logic [DATA_W-1:0] fifo_wr_data,
  input logic              fifo_flush,
  input logic              in_block,
  input logic              discard_flag
);
  // R2
  wr_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> in_valid && (fifo_wr_data == in_data));
  // R10
  flag_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard_flag |-> !fifo_wr_en);
  // R10
  midframe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_block && !in_sof) |-> !fifo_wr_en);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_flag && !clr_discard) |=> discard_flag);
  // R11
  flush_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (discard_flag && in_block));
  // R7
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!discard_flag && !in_valid && !(sys_abort && rd_active)) |=> !fifo_flush);
endmodule

bind rx_discard_filter rx_discard_filter_chk u_chk (.*);

// File: tb/tb_rx_discard_filter.sv
module tb_rx_discard_filter;
  logic       clk = 0, rst_n = 0;
  logic       in_valid = 0, in_sof = 0, in_eof = 0, crc_err = 0, fifo_full = 0;
  logic       rd_active = 0, sys_abort = 0, clr_discard = 0;
  logic [7:0] in_data = 0;
  logic [4:0] keep_mask = 0;
  logic [3:0] max_sel = 0;
  logic       fifo_wr_en, fifo_flush, in_block, discard_flag;
  logic [7:0] fifo_wr_data;

  int n_cmp = 0, n_bad = 0, flushes = 0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  rx_discard_filter dut (.*);

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fifo_flush) flushes++;
    if (rst_n && fifo_wr_en) begin
      n_cmp++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R2 actual=%0d expected=none", fifo_wr_data);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (e != fifo_wr_data) begin
          n_bad++;
          $display("FAIL R2 actual=%0d expected=%0d", fifo_wr_data, e);
        end
      end
    end
  end

  task automatic send(int len, bit crc, int full_at, int keep_n, int clr_at, int seed);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid    = 1;
      in_sof      = (i == 0);
      in_eof      = (i == len - 1);
      in_data     = 8'(i + seed);
      crc_err     = crc && (i == len - 1);
      fifo_full   = (i == full_at);
      clr_discard = (i == clr_at);
      if (i < keep_n) expq.push_back(8'(i + seed));
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0; crc_err = 0; fifo_full = 0; clr_discard = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic clear();
    @(posedge clk); #1; clr_discard = 1;
    @(posedge clk); #1; clr_discard = 0;
  endtask

  task automatic queue_drained(string req);
    chk(req, expq.size(), 0);
    expq.delete();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int f0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flag", discard_flag, 0);
    chk("R1 block", in_block, 0);
    chk("R1 flush", fifo_flush, 0);
    rst_n = 1;

    f0 = flushes; send(100, 0, -1, 100, -1, 3);
    chk("R2 no flush", flushes - f0, 0); queue_drained("R2");
    f0 = flushes; send(64, 0, -1, 64, -1, 7);
    chk("R4 64 kept", flushes - f0, 0); queue_drained("R4");
    f0 = flushes; send(1518, 0, -1, 1518, -1, 1);
    chk("R5 max kept", flushes - f0, 0); queue_drained("R5");

    f0 = flushes; send(80, 1, -1, 79, -1, 9);
    chk("R3 flush", flushes - f0, 1); chk("R3 flag", discard_flag, 1);
    queue_drained("R9"); clear();
    chk("R10 cleared", discard_flag, 0);

    f0 = flushes; send(63, 0, -1, 62, -1, 11);
    chk("R4 flush", flushes - f0, 1); queue_drained("R4"); clear();

    f0 = flushes; send(1530, 0, -1, 1518, -1, 5);
    chk("R5 flush", flushes - f0, 1); queue_drained("R5"); clear();

    max_sel = 15;
    f0 = flushes; send(1533, 0, -1, 1533, -1, 2);
    chk("R5 1533 kept", flushes - f0, 0); queue_drained("R5");
    f0 = flushes; send(1534, 0, -1, 1533, -1, 4);
    chk("R5 1534 flush", flushes - f0, 1); queue_drained("R5"); clear();
    max_sel = 0;

    f0 = flushes; send(100, 0, 10, 10, -1, 6);
    chk("R6 flush", flushes - f0, 1); queue_drained("R6");
    f0 = flushes; send(70, 0, -1, 0, -1, 8);
    chk("R10 held blocked", flushes - f0, 0); queue_drained("R10");
    clear();
    f0 = flushes; send(100, 0, 10, 10, 13, 12);
    chk("R10 midframe clr flag", discard_flag, 0); queue_drained("R10");
    send(70, 0, -1, 70, -1, 14); queue_drained("R10 resume");

    keep_mask = 5'b01111;
    f0 = flushes;
    send(90, 1, 20, 90, -1, 15);
    send(40, 0, -1, 40, -1, 16);
    send(1525, 0, -1, 1525, -1, 17);
    chk("R8 no flush", flushes - f0, 0); queue_drained("R8");
    keep_mask = 5'b10000;
    @(posedge clk); #1; sys_abort = 1; rd_active = 1;
    @(posedge clk); #1; sys_abort = 0; rd_active = 0;
    repeat (2) @(posedge clk);
    #1; chk("R8 abort kept", flushes - f0, 0);
    keep_mask = 0;

    f0 = flushes;
    @(posedge clk); #1; sys_abort = 1;
    @(posedge clk); #1; sys_abort = 0;
    repeat (2) @(posedge clk);
    #1; chk("R7 ignored", flushes - f0, 0); chk("R7 ignored flag", discard_flag, 0);
    @(posedge clk); #1; sys_abort = 1; rd_active = 1;
    @(posedge clk); #1; sys_abort = 0; rd_active = 0;
    repeat (2) @(posedge clk);
    #1; chk("R7 flush", flushes - f0, 1); chk("R7 flag", discard_flag, 1);

    @(posedge clk); #1; sys_abort = 1; rd_active = 1; clr_discard = 1;
    @(posedge clk); #1; sys_abort = 0; rd_active = 0; clr_discard = 0;
    @(negedge clk);
    chk("R11 flag kept", discard_flag, 1);
    clear();
    chk("R10 clear", discard_flag, 0);
    summary();
  end
endmodule